// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Multi-Entry Queue

This block keeps the header record of an uncorrectable error for a link endpoint. The record is a pointer to the status bit of the first error, four 32-bit header words and four 32-bit prefix words, with a flag that tells whether the prefix words are valid. The block also owns the 32-bit uncorrectable status register. An upstream classifier hands it one error at a time through a log request. Software clears status bits through a write-one-to-clear port.

When multi-entry recording is switched on and the first error is still pending, later errors wait in a queue of parameterised depth behind the live record. Once software clears the first error's status bit, the oldest queued error moves into the record. Before that happens, the status bits of every queued error are raised again, so that no pending error drops out of view. A request that arrives while the queue is full is dropped and reported with a one-cycle overflow pulse.

All outputs are registered and show the effect of an input one clock after the edge that samples it.

Top module: `hdr_err_log`

## Requirements
- R1: An accepted log request that goes straight to the record sets `first_ptr` to the index of its single set status bit. Every accepted request also sets that bit in `uncor_status`.
- R2: Loading a record stores the four header words when the header-valid flag is 1, and otherwise sets `hdr_log` to zero.
- R3: Loading a record stores the prefix words and sets `pfx_flag` only when the request's prefix flag and `pfx_en` are both 1. Otherwise `pfx_log` is zero and `pfx_flag` is 0.
- R4: With `mhr_en` = 1 and `uncor_status[first_ptr]` set, a request is appended to the queue (`pend_count` rises by one) and the record stays as it was.
- R5: A request that would be appended to a full queue is dropped: `pend_count` stays unchanged and `overflow` is 1 for exactly one cycle.
- R6: A write that clears `uncor_status[first_ptr]` while `mhr_en` = 1 and the queue is not empty first sets the status bits of all queued entries again. It then moves the oldest entry into the record (by R1 to R3) and removes it from the queue.
- R7: A write that clears `uncor_status[first_ptr]` while the queue is empty or `mhr_en` = 0 sets `first_ptr`, `pfx_flag`, `hdr_log` and `pfx_log` to zero. After reset, every output except `mhr_capable` is zero.
- R8: With `mhr_en` = 1, a write that leaves `uncor_status[first_ptr]` set still sets the status bits of all queued entries, which undoes any clear of them.
- R9: With `mhr_en` = 0, a write that leaves `uncor_status[first_ptr]` set empties the queue.
- R10: `mhr_capable` is 1 exactly when the parameter QDEPTH is greater than zero.
- R11: A log request whose status has zero set bits, or more than one set bit, is ignored.
- R12: When a write and a log request arrive in the same cycle, the write is applied first and the request is evaluated against the state the write leaves behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_req | input | 1 | Log request strobe from the classifier |
| log_status | input | 32 | Status bit of the error; must be one-hot |
| log_hdr_vld | input | 1 | Header words of the request are valid |
| log_pfx_vld | input | 1 | Request carries prefix words |
| log_hdr | input | 128 | Four header words |
| log_pfx | input | 128 | Four prefix words |
| mhr_en | input | 1 | Multi-entry recording enable |
| pfx_en | input | 1 | End-to-end prefix support enabled |
| wr_en | input | 1 | Write-one-to-clear strobe on the status register |
| wr_mask | input | 32 | Bits to clear |
| uncor_status | output | 32 | Uncorrectable status register |
| first_ptr | output | 5 | Index of the first-error status bit |
| hdr_log | output | 128 | Header record |
| pfx_log | output | 128 | Prefix record |
| pfx_flag | output | 1 | Prefix record valid |
| pend_count | output | 4 | Number of queued entries |
| overflow | output | 1 | One-cycle pulse for a dropped request |
| mhr_capable | output | 1 | Multi-entry recording is supported |

## Verification
Directed sequences cover each edge on its own. One sequence fills the queue and then pushes past the last slot, which separates a correct drop from a wrap or an overwrite. Another clears a queued bit while the first error stays pending, which shows whether the restore takes place. A request with several status bits set is sent, and a write and a request are driven in the same cycle to expose the order in which they are applied. Random traffic then mixes the enables, header and prefix flags, and the clear masks. Some masks hit the pointed-to bit, some hit other bits, and some clear nothing, so pop, flush, restore and plain clear each occur many times against the bench's model of the record and the queue.

// File: rtl/hdr_err_log.sv
module hdr_err_log #(
  parameter int QDEPTH = 8,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       log_req,
  input  logic [31:0]                log_status,
  input  logic                       log_hdr_vld,
  input  logic                       log_pfx_vld,
  input  logic [WORD_W*NWORDS-1:0]   log_hdr,
  input  logic [WORD_W*NWORDS-1:0]   log_pfx,
  input  logic                       mhr_en,
  input  logic                       pfx_en,
  input  logic                       wr_en,
  input  logic [31:0]                wr_mask,
  output logic [31:0]                uncor_status,
  output logic [4:0]                 first_ptr,
  output logic [WORD_W*NWORDS-1:0]   hdr_log,
  output logic [WORD_W*NWORDS-1:0]   pfx_log,
  output logic                       pfx_flag,
  output logic [$clog2(QDEPTH+2)-1:0] pend_count,
  output logic                       overflow,
  output logic                       mhr_capable
);
  localparam int HW = WORD_W * NWORDS;
  localparam int QD = (QDEPTH > 0) ? QDEPTH : 1;
  localparam int CW = $clog2(QDEPTH + 2);
  localparam logic [CW-1:0] QFULL = CW'(QDEPTH);

  typedef struct packed {
    logic [31:0]   st;
    logic          hv;
    logic          pv;
    logic [HW-1:0] hdr;
    logic [HW-1:0] pfx;
  } ent_t;

  logic [31:0]   st_q, st_n;
  logic [4:0]    fep_q, fep_n;
  logic [HW-1:0] hl_q, hl_n, pl_q, pl_n;
  logic          pf_q, pf_n, ovf_q, ovf_n;
  logic [CW-1:0] cnt_q, cnt_n;
  ent_t          mem_q [QD];
  ent_t          mem_n [QD];
  ent_t          req_e;
  logic [31:0]   qor;
  logic          req_ok;

  function automatic logic [4:0] bit_idx(input logic [31:0] v);
    bit_idx = '0;
    for (int i = 31; i >= 0; i--)
      if (v[i]) bit_idx = i[4:0];
  endfunction

  assign req_ok = log_req && (log_status != '0) && ((log_status & (log_status - 32'd1)) == '0);
  assign req_e  = '{st: log_status, hv: log_hdr_vld, pv: log_pfx_vld, hdr: log_hdr, pfx: log_pfx};

  always_comb begin
    qor = '0;
    for (int i = 0; i < QD; i++)
      if (CW'(i) < cnt_q) qor = qor | mem_q[i].st;
  end

  always_comb begin
    st_n  = st_q;
    fep_n = fep_q;
    hl_n  = hl_q;
    pl_n  = pl_q;
    pf_n  = pf_q;
    cnt_n = cnt_q;
    ovf_n = 1'b0;
    for (int i = 0; i < QD; i++) mem_n[i] = mem_q[i];

    if (wr_en) begin
      st_n = st_n & ~wr_mask;
      if (!st_n[fep_n]) begin
        if (mhr_en && cnt_n != '0) begin
          st_n  = st_n | qor;
          fep_n = bit_idx(mem_n[0].st);
          hl_n  = mem_n[0].hv ? mem_n[0].hdr : '0;
          pf_n  = mem_n[0].pv && pfx_en;
          pl_n  = pf_n ? mem_n[0].pfx : '0;
          for (int i = 0; i < QD - 1; i++) mem_n[i] = mem_n[i+1];
          cnt_n = cnt_n - 1'b1;
        end else begin
          fep_n = '0;
          hl_n  = '0;
          pl_n  = '0;
          pf_n  = 1'b0;
        end
      end else if (mhr_en) begin
        st_n = st_n | qor;
      end else begin
        cnt_n = '0;
      end
    end

    if (req_ok) begin
      if (mhr_en && st_n[fep_n]) begin
        if (cnt_n == QFULL) begin
          ovf_n = 1'b1;
        end else begin
          for (int i = 0; i < QD; i++)
            if (CW'(i) == cnt_n) mem_n[i] = req_e;
          cnt_n = cnt_n + 1'b1;
        end
      end else begin
        fep_n = bit_idx(log_status);
        hl_n  = log_hdr_vld ? log_hdr : '0;
        pf_n  = log_pfx_vld && pfx_en;
        pl_n  = pf_n ? log_pfx : '0;
      end
      st_n = st_n | log_status;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      fep_q <= '0;
      hl_q  <= '0;
      pl_q  <= '0;
      pf_q  <= 1'b0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < QD; i++) mem_q[i] <= '0;
    end else begin
      st_q  <= st_n;
      fep_q <= fep_n;
      hl_q  <= hl_n;
      pl_q  <= pl_n;
      pf_q  <= pf_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
      for (int i = 0; i < QD; i++) mem_q[i] <= mem_n[i];
    end
  end

  assign uncor_status = st_q;
  assign first_ptr    = fep_q;
  assign hdr_log      = hl_q;
  assign pfx_log      = pl_q;
  assign pfx_flag     = pf_q;
  assign pend_count   = cnt_q;
  assign overflow     = ovf_q;
  assign mhr_capable  = (QDEPTH > 0);

  assert_status_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (log_req && $onehot(log_status) && !mhr_en) |=> uncor_status[first_ptr]);

  assert_prefix_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_flag |-> (pfx_log == '0));

  assert_grow_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_count > $past(pend_count)) |-> $past(log_req));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($past(pend_count) == QFULL && $stable(pend_count)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mhr_en && uncor_status[first_ptr] && !wr_mask[first_ptr]) |=> (pend_count == '0));

  assert_bad_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && log_req && !$onehot(log_status)) |=> $stable(uncor_status));
endmodule

// File: tb/hdr_err_log_bench.sv
`timescale 1ns/1ps
module hdr_err_log_bench;
  localparam int QD = 8;
  logic clk = 0, rst_n = 0;
  logic log_req = 0, log_hdr_vld = 0, log_pfx_vld = 0, mhr_en = 0, pfx_en = 0, wr_en = 0;
  logic [31:0] log_status = 0, wr_mask = 0;
  logic [127:0] log_hdr = 0, log_pfx = 0;
  logic [31:0] uncor_status;
  logic [4:0] first_ptr;
  logic [127:0] hdr_log, pfx_log;
  logic pfx_flag, overflow, mhr_capable;
  logic [3:0] pend_count;

  hdr_err_log u_hdr_err_log (
    .clk(clk), .rst_n(rst_n), .log_req(log_req), .log_status(log_status),
    .log_hdr_vld(log_hdr_vld), .log_pfx_vld(log_pfx_vld), .log_hdr(log_hdr),
    .log_pfx(log_pfx), .mhr_en(mhr_en), .pfx_en(pfx_en), .wr_en(wr_en),
    .wr_mask(wr_mask), .uncor_status(uncor_status), .first_ptr(first_ptr),
    .hdr_log(hdr_log), .pfx_log(pfx_log), .pfx_flag(pfx_flag),
    .pend_count(pend_count), .overflow(overflow), .mhr_capable(mhr_capable));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;

  logic [31:0]  m_st;
  logic [4:0]   m_fep;
  logic [127:0] m_hl, m_pl;
  logic         m_pf, m_ovf;
  int           m_cnt;
  logic [31:0]  q_st [QD];
  logic         q_hv [QD];
  logic         q_pv [QD];
  logic [127:0] q_hdr [QD];
  logic [127:0] q_pfx [QD];

  function automatic logic [4:0] low_bit(input logic [31:0] v);
    logic [4:0] r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i[4:0];
    return r;
  endfunction

  function automatic bit one_hot(input logic [31:0] v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  task automatic m_load(input logic [31:0] s, input logic hv, input logic pv,
                        input logic [127:0] h, input logic [127:0] p, input logic pe);
    m_fep = low_bit(s);
    m_hl  = hv ? h : 128'd0;
    m_pf  = pv && pe;
    m_pl  = m_pf ? p : 128'd0;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " status"}, {96'd0, uncor_status}, {96'd0, m_st});
    chk({tag, " ptr"}, {123'd0, first_ptr}, {123'd0, m_fep});
    chk({tag, " hdr"}, hdr_log, m_hl);
    chk({tag, " pfx"}, pfx_log, m_pl);
    chk({tag, " pflag"}, {127'd0, pfx_flag}, {127'd0, m_pf});
    chk({tag, " count"}, {124'd0, pend_count}, 128'(m_cnt));
    chk({tag, " ovf"}, {127'd0, overflow}, {127'd0, m_ovf});
  endtask

  task automatic step(input string tag, input logic rq, input logic [31:0] s,
                      input logic hv, input logic pv, input logic [127:0] h,
                      input logic [127:0] p, input logic mhr, input logic pe,
                      input logic wr, input logic [31:0] msk);
    log_req = rq; log_status = s; log_hdr_vld = hv; log_pfx_vld = pv;
    log_hdr = h; log_pfx = p; mhr_en = mhr; pfx_en = pe; wr_en = wr; wr_mask = msk;
    m_ovf = 0;
    if (wr) begin
      m_st = m_st & ~msk;
      if (!m_st[m_fep]) begin
        if (mhr && m_cnt > 0) begin
          for (int i = 0; i < m_cnt; i++) m_st = m_st | q_st[i];
          m_load(q_st[0], q_hv[0], q_pv[0], q_hdr[0], q_pfx[0], pe);
          for (int i = 0; i < QD - 1; i++) begin
            q_st[i] = q_st[i+1]; q_hv[i] = q_hv[i+1]; q_pv[i] = q_pv[i+1];
            q_hdr[i] = q_hdr[i+1]; q_pfx[i] = q_pfx[i+1];
          end
          m_cnt--;
        end else begin
          m_fep = 0; m_hl = 0; m_pl = 0; m_pf = 0;
        end
      end else if (mhr) begin
        for (int i = 0; i < m_cnt; i++) m_st = m_st | q_st[i];
      end else begin
        m_cnt = 0;
      end
    end
    if (rq && one_hot(s)) begin
      if (mhr && m_st[m_fep]) begin
        if (m_cnt == QD) m_ovf = 1;
        else begin
          q_st[m_cnt] = s; q_hv[m_cnt] = hv; q_pv[m_cnt] = pv;
          q_hdr[m_cnt] = h; q_pfx[m_cnt] = p; m_cnt++;
        end
      end else m_load(s, hv, pv, h, p, pe);
      m_st = m_st | s;
    end
    @(negedge clk);
    check_all(tag);
    log_req = 0; wr_en = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = 0; m_fep = 0; m_hl = 0; m_pl = 0; m_pf = 0; m_ovf = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R7 reset");
    chk("R10 capable", {127'd0, mhr_capable}, 128'd1);

    step("R1 R2 R3 first log", 1, 32'h10, 1, 1, {4{32'hA5A5_0001}}, {4{32'h0BAD_F00D}}, 1, 1, 0, 0);
    step("R4 queued", 1, 32'h80, 0, 1, 128'h1234, 128'h5678, 1, 0, 0, 0);
    for (int i = 0; i < 7; i++)
      step("R4 fill", 1, 32'h1 << (i + 9), i[0], 1, rnd128(), rnd128(), 1, 1, 0, 0);
    step("R5 overflow", 1, 32'h1 << 20, 1, 0, rnd128(), 0, 1, 1, 0, 0);
    step("R5 pulse ends", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    step("R8 restore", 0, 0, 0, 0, 0, 0, 1, 1, 1, 32'h0000_0280);
    step("R6 pop", 0, 0, 0, 0, 0, 0, 1, 1, 1, 32'h10);
    step("R11 multi bit", 1, 32'h0000_0003, 1, 1, rnd128(), rnd128(), 0, 1, 0, 0);
    step("R11 zero bits", 1, 32'h0, 1, 1, rnd128(), rnd128(), 0, 1, 0, 0);
    step("R12 write then log", 1, 32'h4000_0000, 1, 1, rnd128(), rnd128(), 1, 1, 1, 32'h80);
    step("R9 flush", 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'h0);
    step("R7 clear", 0, 0, 0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    step("R2 no header", 1, 32'h8, 0, 1, rnd128(), rnd128(), 0, 0, 0, 0);
    step("R3 prefix disabled", 1, 32'h4, 1, 1, rnd128(), rnd128(), 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      logic rq, wr, mhr, pe, hv, pv;
      logic [31:0] s, msk;
      int sel;
      rq  = ($urandom % 3) != 0;
      wr  = ($urandom % 3) == 0;
      mhr = ($urandom % 8) != 0;
      pe  = $urandom % 2;
      hv  = $urandom % 2;
      pv  = $urandom % 2;
      sel = $urandom % 10;
      s = (sel == 0) ? $urandom : (sel == 1) ? 32'd0 : (32'h1 << ($urandom % 32));
      sel = $urandom % 4;
      msk = (sel == 0) ? (32'h1 << m_fep) : (sel == 1) ? 32'd0 :
            (sel == 2) ? $urandom : (32'h1 << ($urandom % 32));
      step("R6 random", rq, s, hv, pv, rnd128(), rnd128(), mhr, pe, wr, msk);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule